// File: doc/BRIEF.md
# Dual-Channel Timer Input Capture Unit

This block is a 16-bit free-running counter with two input capture channels, reached through a byte-wide register port. Each channel watches one external pin. When the pin makes the transition chosen for that channel, the channel stores the counter value in a 16-bit capture register and raises its capture flag. Software reads the stored value as two bytes. It clears the flag with a two-step handshake: a status read while the flag is set, then an access to the channel's low byte.

The counter advances at a rate set by a 2-bit rate field. The rate is the system clock divided by 2, 4 or 8, or the rising edges of an external clock pin. When the counter passes from 0xFFFF to 0x0000 it sets an overflow flag, so software can measure intervals longer than one counter period. A read of a high capture byte locks that channel until its low byte is accessed, so the two bytes always come from the same event. A mode input stops channel 1 from capturing while the timer runs a waveform mode. One interrupt request line covers both channels.

Top module: `cap_timer_unit`

## Requirements
- R1: After reset the control register, status register, counter and both capture registers read 0, and `irq_o` is low.
- R2: The control register at address 0 holds the rate field in bits 4:3. The counter steps when the free-running prescaler count (reset to 0) satisfies count mod N == N-1, with N = 4 for code 00, N = 8 for code 01 and N = 2 for code 10. Code 11 steps the counter once per rising edge of `ext_clk_i`.
- R3: Control bit 0 (channel 1) and bit 1 (channel 2) select the active edge: 1 for rising, 0 for falling. On the active edge, after the two-flop pin synchronizer, the channel stores the counter value held two clock edges after the pin change. Its flag appears in status bit 0 (channel 1) or bit 1 (channel 2) one edge later.
- R4: A transition in the direction not selected stores nothing and sets no flag.
- R5: `irq_o` is high exactly when a capture flag is set, control bit 2 (interrupt enable) is 1 and `irq_mask_i` is 0.
- R6: A flag clears only when a status read (address 1) made while the flag is set is followed by a read or a write of that channel's low byte (address 3 for channel 1, 5 for channel 2). A low-byte access without that status read leaves the flag set, and a capture between the two steps cancels the first step.
- R7: A read of a channel's high byte (address 2 or 4) blocks new captures and flag setting on that channel until its low byte is accessed.
- R8: A later capture overwrites the stored value, so the register always holds the most recent event.
- R9: While `pwm_mode_i` is high, channel 1 never captures and channel 2 works normally.
- R10: When the counter steps from 0xFFFF it wraps to 0 and sets status bit 2. That bit clears on a read of address 7 that follows a status read made while the bit was set. A write to address 7 loads 0xFFFC into the counter and restarts the prescaler.
- R11: If a capture falls in the same cycle as the low-byte access that would clear its flag, the flag stays set and the new value is stored. If a wrap falls in the same cycle as the overflow clear, the overflow bit stays set.
- R12: The address map is: 0 control (bits 7:5 read 0), 1 status, 2 and 3 channel 1 high and low, 4 and 5 channel 2 high and low, 6 and 7 counter high and low. Writes to the capture bytes do not change their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_i | input | 1 | External count clock, used when the rate code is 11 |
| cap_pin_i | input | 2 | Capture pins; bit 0 feeds channel 1, bit 1 feeds channel 2 |
| pwm_mode_i | input | 1 | High while a waveform mode runs; turns channel 1 off |
| irq_mask_i | input | 1 | Global interrupt mask; holds the request pending while high |
| bus_addr_i | input | 3 | Register address |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall on the same clock edge. A capture can meet the low-byte access that completes the flag-clearing handshake, and a counter wrap can meet the counter-low read that clears overflow. The bench first arms the handshake with a status read. It then sets the pin change or the counter load so that the third edge after it, or the wrap, lands on the cycle where the clearing read is on the bus. It judges the result from a later status read, which must show the flag still set, and from the capture bytes, which must hold the new value. Every edge-select and transition-direction combination is swept on both channels, and the counter and capture values are predicted from a cycle-exact prescaler model.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int NCH    = 2;
    localparam int PRE_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_STAT = 3'd1,
        A_C1H  = 3'd2,
        A_C1L  = 3'd3,
        A_C2H  = 3'd4,
        A_C2L  = 3'd5,
        A_CNTH = 3'd6,
        A_CNTL = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        RATE_DIV4 = 2'b00,
        RATE_DIV8 = 2'b01,
        RATE_DIV2 = 2'b10,
        RATE_EXT  = 2'b11
    } rate_e;

    localparam logic [CNT_W-1:0] CNT_LOAD = 16'hFFFC;

    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic             flag;
        logic             armed;
        logic             lock;
    } chan_st_t;

    typedef struct packed {
        logic [1:0]       rate;
        logic             irq_en;
        logic [NCH-1:0]   edge_rise;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             ovf_arm;
    } top_st_t;
endpackage

// File: rtl/ctu_pin_edge.sv
module ctu_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_i,
    output logic hit_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } pe_st_t;

    pe_st_t st_q, st_d;
    logic   lvl;

    assign lvl   = st_q.sync[STAGES-1];
    assign hit_o = (lvl != st_q.prev) && (lvl == rise_i);

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin_i};
        st_d.prev = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // An edge report lasts exactly one cycle (R3)
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);
endmodule

// File: rtl/ctu_rate_gen.sv
module ctu_rate_gen
    import ctu_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_i,
    input  logic       ext_i,
    input  logic       restart_i,
    output logic       tick_o
);
    logic [PW-1:0] pre_q, pre_d;
    logic          ext_hit;

    ctu_pin_edge #(.STAGES(2)) i_ext_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_i),
        .rise_i (1'b1),
        .hit_o  (ext_hit)
    );

    always_comb begin
        pre_d = restart_i ? '0 : pre_q + 1'b1;
    end

    always_comb begin
        unique case (rate_e'(rate_i))
            RATE_DIV4: tick_o = (pre_q[1:0] == 2'b11);
            RATE_DIV8: tick_o = (pre_q[2:0] == 3'b111);
            RATE_DIV2: tick_o = pre_q[0];
            default:   tick_o = ext_hit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // Internal divisors never produce ticks on consecutive cycles (R2)
    assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_i != RATE_EXT && tick_o) |=> (!tick_o || rate_i == RATE_EXT));
endmodule

// File: rtl/ctu_capture_chan.sv
module ctu_capture_chan
    import ctu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             stat_rd_i,
    input  logic             hi_rd_i,
    input  logic             lo_acc_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             flag_o
);
    chan_st_t st_q, st_d;
    logic     take;

    assign take   = hit_i && en_i && !st_q.lock;
    assign cap_o  = st_q.cap;
    assign flag_o = st_q.flag;

    always_comb begin
        st_d = st_q;
        if (stat_rd_i && st_q.flag) st_d.armed = 1'b1;
        if (hi_rd_i)                st_d.lock  = 1'b1;
        if (lo_acc_i) begin
            st_d.lock  = 1'b0;
            st_d.armed = 1'b0;
            if (st_q.armed) st_d.flag = 1'b0;
        end
        if (take) begin
            st_d.cap   = count_i;
            st_d.flag  = 1'b1;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // An accepted edge stores the counter and raises the flag (R3)
    assert_capture_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (st_q.flag && st_q.cap == $past(count_i)));
    // A flag only drops after an armed low-byte access (R6)
    assert_clear_handshake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> ($past(st_q.armed) && $past(lo_acc_i)));
    // A locked channel keeps its stored value (R7)
    assert_locked_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> $stable(st_q.cap));
endmodule

// File: rtl/cap_timer_unit.sv
module cap_timer_unit
    import ctu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk_i,
    input  logic [NCH-1:0]    cap_pin_i,
    input  logic              pwm_mode_i,
    input  logic              irq_mask_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    output logic [BYTE_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    top_st_t st_q, st_d;

    logic                      tick;
    logic                      stat_rd, cnt_load, cnt_lo_rd, ctrl_wr;
    logic [NCH-1:0]            flag_w;
    logic [NCH-1:0][CNT_W-1:0] cap_w;
    logic                      unused_wbits;

    assign unused_wbits = ^bus_wdata_i[7:5];
    assign stat_rd   = bus_rd_i && (bus_addr_i == A_STAT);
    assign cnt_load  = bus_wr_i && (bus_addr_i == A_CNTL);
    assign cnt_lo_rd = bus_rd_i && (bus_addr_i == A_CNTL);
    assign ctrl_wr   = bus_wr_i && (bus_addr_i == A_CTRL);

    ctu_rate_gen i_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_i    (st_q.rate),
        .ext_i     (ext_clk_i),
        .restart_i (cnt_load),
        .tick_o    (tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(2 + 2 * g);
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(3 + 2 * g);
        logic hit, en;

        if (g == 0) begin : g_gated
            assign en = !pwm_mode_i;
        end else begin : g_free
            assign en = 1'b1;
        end

        ctu_pin_edge #(.STAGES(2)) i_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (cap_pin_i[g]),
            .rise_i (st_q.edge_rise[g]),
            .hit_o  (hit)
        );

        ctu_capture_chan i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_i     (hit),
            .en_i      (en),
            .count_i   (st_q.cnt),
            .stat_rd_i (stat_rd),
            .hi_rd_i   (bus_rd_i && (bus_addr_i == HI_A)),
            .lo_acc_i  ((bus_rd_i || bus_wr_i) && (bus_addr_i == LO_A)),
            .cap_o     (cap_w[g]),
            .flag_o    (flag_w[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.edge_rise = bus_wdata_i[NCH-1:0];
            st_d.irq_en    = bus_wdata_i[2];
            st_d.rate      = bus_wdata_i[4:3];
        end
        if (stat_rd && st_q.ovf) st_d.ovf_arm = 1'b1;
        if (cnt_lo_rd) begin
            st_d.ovf_arm = 1'b0;
            if (st_q.ovf_arm) st_d.ovf = 1'b0;
        end
        if (cnt_load) begin
            st_d.cnt = CNT_LOAD;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (&st_q.cnt) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr_e'(bus_addr_i))
            A_CTRL:  bus_rdata_o = {3'b000, st_q.rate, st_q.irq_en, st_q.edge_rise};
            A_STAT:  bus_rdata_o = {5'b00000, st_q.ovf, flag_w};
            A_C1H:   bus_rdata_o = cap_w[0][15:8];
            A_C1L:   bus_rdata_o = cap_w[0][7:0];
            A_C2H:   bus_rdata_o = cap_w[1][15:8];
            A_C2L:   bus_rdata_o = cap_w[1][7:0];
            A_CNTH:  bus_rdata_o = st_q.cnt[15:8];
            default: bus_rdata_o = st_q.cnt[7:0];
        endcase
    end

    assign irq_o = (|flag_w) && st_q.irq_en && !irq_mask_i;

    // Wrap from all ones lands on zero with overflow raised (R10)
    assert_wrap_sets_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.cnt && tick && !cnt_load) |=> (st_q.cnt == '0 && st_q.ovf));
    // Channel 1 stored value is frozen in waveform mode (R9)
    assert_ch1_off_in_pwm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_mode_i |=> $stable(cap_w[0]));
endmodule

// File: tb/test_cap_timer_unit.sv
module test_cap_timer_unit;
    import ctu_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0, ext = 1'b0, pwm = 1'b0, mask = 1'b0;
    logic [1:0] pins = 2'b00;
    logic [2:0] addr = 3'd0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = 8'h00, rdata;
    logic       irq;

    int checks = 0, errors = 0;
    logic [15:0] cnt_m;
    logic [2:0]  pre_m;
    logic [1:0]  sel_m;
    logic [15:0] last_cap [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_timer_unit i_cap_timer_unit (
        .clk(clk), .rst_n(rst_n), .ext_clk_i(ext), .cap_pin_i(pins),
        .pwm_mode_i(pwm), .irq_mask_i(mask), .bus_addr_i(addr),
        .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq));

    // Arithmetic counter model from R2 and R10
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt_m <= '0; pre_m <= '0; sel_m <= '0;
        end else begin
            if (wr && addr == 3'd0) sel_m <= wdata[4:3];
            if (wr && addr == 3'd7) begin
                cnt_m <= 16'hFFFC; pre_m <= '0;
            end else begin
                pre_m <= pre_m + 3'd1;
                if ((sel_m == 2'd0 && pre_m[1:0] == 2'd3) ||
                    (sel_m == 2'd1 && pre_m == 3'd7) ||
                    (sel_m == 2'd2 && pre_m[0]))
                    cnt_m <= cnt_m + 16'd1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        #(CLK_PERIOD/4) d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wr = 1'b1; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        do_rd(a, d);
        chk(req, d, exp);
    endtask

    // Drive a pin level; return the counter value the capture must hold (R3)
    task automatic pulse(input int ch, input logic v, output logic [15:0] e);
        pins[ch] = v;
        @(posedge clk); @(posedge clk); #1 e = cnt_m;
        @(negedge clk);
    endtask

    task automatic clear_all();
        logic [7:0] d;
        do_rd(3'd1, d); do_rd(3'd3, d); do_rd(3'd5, d);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] e, e1, e2;
        logic [7:0]  d;
        idle(3); rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 ctrl", 3'd0, 8'h00);
        rd_chk("R1 status", 3'd1, 8'h00);
        rd_chk("R1 cap1 hi", 3'd2, 8'h00);
        rd_chk("R1 cap2 lo", 3'd5, 8'h00);
        rd_chk("R1 counter hi", 3'd6, 8'h00);
        chk("R1 irq", irq, 0);
        last_cap[0] = '0; last_cap[1] = '0;

        // R12 control layout and read-only capture bytes
        do_wr(3'd0, 8'hFF);
        rd_chk("R12 ctrl readback", 3'd0, 8'h1F);
        do_wr(3'd2, 8'hA5);
        rd_chk("R12 cap1 hi write ignored", 3'd2, 8'h00);

        // R2 rate sweep against the model
        for (int r = 0; r < 3; r++) begin
            do_wr(3'd0, 8'(r << 3));
            for (int i = 0; i < 5; i++) begin
                idle(3 + i);
                rd_chk("R2 counter lo", 3'd7, cnt_m[7:0]);
                rd_chk("R2 counter hi", 3'd6, cnt_m[15:8]);
            end
        end

        // R3/R4 sweep: channel x edge select x transition direction
        for (int ch = 0; ch < 2; ch++) begin
            for (int s = 0; s < 2; s++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    do_wr(3'd0, 8'h10 | 8'(s << ch));
                    pulse(ch, !dir[0], e);
                    idle(3);
                    clear_all();
                    do_rd(3'd1, d);
                    chk("R6 sweep flags cleared", d[1:0], 0);
                    if (pins[ch] != !dir[0]) chk("sweep pin setup", pins[ch], !dir[0]);
                    // capture may have happened during setup; resync last value
                    do_rd(ch ? 3'd4 : 3'd2, d); last_cap[ch][15:8] = d;
                    do_rd(ch ? 3'd5 : 3'd3, d); last_cap[ch][7:0] = d;
                    pulse(ch, dir[0], e);
                    idle(2);
                    do_rd(3'd1, d);
                    if (dir == s) begin
                        chk("R3 flag on active edge", d[1:0], 1 << ch);
                        rd_chk("R3 capture hi", ch ? 3'd4 : 3'd2, e[15:8]);
                        rd_chk("R3 capture lo", ch ? 3'd5 : 3'd3, e[7:0]);
                        last_cap[ch] = e;
                    end else begin
                        chk("R4 no flag on other edge", d[1:0], 0);
                        rd_chk("R4 value unchanged", ch ? 3'd5 : 3'd3, last_cap[ch][7:0]);
                    end
                    clear_all();
                end
            end
        end

        // R7 lock, R8 overwrite, on channel 2 with rising edges
        do_wr(3'd0, 8'h13);
        pulse(1, 1'b0, e); idle(3); clear_all();
        pulse(1, 1'b1, e1); idle(2);
        rd_chk("R7 hi read of first", 3'd4, e1[15:8]);
        pulse(1, 1'b0, e); pulse(1, 1'b1, e2); idle(2);
        do_rd(3'd1, d);
        chk("R7 flag still from first", d[1], 1);
        rd_chk("R7 blocked capture lo", 3'd5, e1[7:0]);
        do_rd(3'd1, d);
        chk("R7 no flag from blocked edge", d[1], 0);
        pulse(1, 1'b0, e); pulse(1, 1'b1, e1);
        pulse(1, 1'b0, e); pulse(1, 1'b1, e2); idle(2);
        rd_chk("R8 newest hi", 3'd4, e2[15:8]);
        rd_chk("R8 newest lo", 3'd5, e2[7:0]);

        // R6 handshake details
        rd_chk("R6 unarmed lo access", 3'd5, e2[7:0]);
        do_rd(3'd1, d);
        chk("R6 flag survives unarmed access", d[1], 1);
        pulse(1, 1'b0, e); pulse(1, 1'b1, e1); idle(2);
        rd_chk("R6 lo after cancel", 3'd5, e1[7:0]);
        do_rd(3'd1, d);
        chk("R6 capture cancels arming", d[1], 1);
        rd_chk("R6 armed lo read", 3'd5, e1[7:0]);
        do_rd(3'd1, d);
        chk("R6 cleared by handshake", d[1], 0);
        pulse(1, 1'b0, e); pulse(1, 1'b1, e1); idle(2);
        do_rd(3'd1, d);
        do_wr(3'd5, 8'h55);
        do_rd(3'd1, d);
        chk("R6 cleared by lo write", d[1], 0);
        rd_chk("R12 lo write ignored", 3'd5, e1[7:0]);

        // R11 capture on the same edge as the clearing access
        pulse(1, 1'b0, e); pulse(1, 1'b1, e1); idle(2);
        do_rd(3'd1, d);
        pulse(1, 1'b0, e);
        pulse(1, 1'b1, e2);
        rd_chk("R11 lo at collision", 3'd5, e1[7:0]);
        idle(1);
        do_rd(3'd1, d);
        chk("R11 capture beats clear", d[1], 1);
        rd_chk("R11 new hi", 3'd4, e2[15:8]);
        rd_chk("R11 new lo", 3'd5, e2[7:0]);

        // R5 interrupt request
        clear_all();
        pulse(1, 1'b0, e); pulse(1, 1'b1, e); idle(2);
        chk("R5 irq off while disabled", irq, 0);
        do_wr(3'd0, 8'h17);
        chk("R5 irq on", irq, 1);
        mask = 1'b1; #1;
        chk("R5 irq masked", irq, 0);
        mask = 1'b0; #1;
        chk("R5 irq after unmask", irq, 1);
        clear_all();
        chk("R5 irq drops after clear", irq, 0);

        // R9 waveform mode disables channel 1
        do_wr(3'd0, 8'h13);
        pulse(0, 1'b0, e); idle(3); clear_all();
        do_rd(3'd2, d); last_cap[0][15:8] = d;
        do_rd(3'd3, d); last_cap[0][7:0] = d;
        pwm = 1'b1;
        pulse(0, 1'b1, e); idle(2);
        do_rd(3'd1, d);
        chk("R9 channel 1 no flag", d[0], 0);
        rd_chk("R9 channel 1 value kept", 3'd3, last_cap[0][7:0]);
        pulse(1, 1'b0, e); pulse(1, 1'b1, e); idle(2);
        do_rd(3'd1, d);
        chk("R9 channel 2 still works", d[1], 1);
        rd_chk("R9 channel 2 value", 3'd5, e[7:0]);
        pwm = 1'b0;
        clear_all();

        // R10 overflow and R11 wrap beating the clear
        do_wr(3'd7, 8'h00);
        rd_chk("R10 load value", 3'd7, 8'hFC);
        idle(10);
        do_rd(3'd1, d);
        chk("R10 overflow set", d[2], 1);
        rd_chk("R10 counter after wrap", 3'd6, cnt_m[15:8]);
        do_rd(3'd1, d);
        do_wr(3'd7, 8'h00);
        idle(7);
        rd_chk("R11 counter lo at wrap edge", 3'd7, 8'hFF);
        do_rd(3'd1, d);
        chk("R11 wrap beats clear", d[2], 1);
        rd_chk("R10 clearing read", 3'd7, cnt_m[7:0]);
        do_rd(3'd1, d);
        chk("R10 overflow cleared", d[2], 0);

        // R2 external count mode
        do_wr(3'd0, 8'h18);
        do_wr(3'd7, 8'h00);
        idle(4);
        rd_chk("R2 ext no pulses", 3'd7, 8'hFC);
        for (int i = 0; i < 5; i++) begin
            ext = 1'b1; idle(3);
            ext = 1'b0; idle(3);
        end
        idle(3);
        rd_chk("R2 ext five pulses", 3'd7, 8'h01);
        idle(10);
        rd_chk("R2 ext held", 3'd7, 8'h01);
        do_rd(3'd1, d);
        chk("R10 ext wrap overflow", d[2], 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule